// File: doc/BRIEF.md
# Vector-Length Bounded Integer Vector ALU

This block is the execution unit of a vector pipeline. It owns a two-dimensional register file of vector registers, each holding up to MVL integer elements. One instruction names a destination register, a second operand register and a first operand. The first operand is either a vector register or a scalar value copied to every element. The unit then applies an add or a multiply to each element in turn, one element per clock.

A separate length register sets how many leading elements an instruction touches. Software writes it before a group of instructions, and the block caps the value at MVL. Destination elements beyond the active length keep their contents. A length of zero turns the instruction into an empty run that still reports completion. Register contents are loaded and inspected through a single-element load port and a combinational read port.

Top module: `vlen_vector_alu`

## Requirements
- R1: After reset the length register reads MVL, busy and done are 0, and every element of every register reads 0.
- R2: A write to the length register with value w makes it read min(w, MVL) from the next cycle on; without a write it holds its value.
- R3: With op=0 (add) and form=0 (vector-vector), element i of the destination becomes srca[i] + srcb[i] modulo 2^64.
- R4: With form=1 (scalar-vector), element i of the destination becomes scalar op srcb[i], using the scalar value sampled in the issue cycle.
- R5: With op=1 (multiply), the result is the low 64 bits of the full product.
- R6: Only elements 0 to VL-1 of the destination are written; elements VL and above keep their previous contents.
- R7: With VL=0 no element changes, and done still pulses for one cycle, in the cycle after the issue edge.
- R8: An accepted issue raises busy for VL+1 cycles. Element i is written at the (i+1)-th edge after the issue edge. done is high only in the last busy cycle, one cycle after the final element write.
- R9: An issue while busy is high is ignored; the running instruction and the registers are unaffected by it.
- R10: When the destination equals a source, each element uses the source's old value.
- R11: An instruction uses the length held before its issue edge. A length write in the same cycle as the issue, or during the run, only affects later instructions.
- R12: The load port writes one element (ld_reg, ld_elem) when busy is low; a load while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vl_we | input | 1 | Length register write strobe |
| vl_wdata | input | 8 | Requested vector length |
| vl_q | output | 6 | Current vector length |
| ld_en | input | 1 | Element load strobe |
| ld_reg | input | 5 | Load target register |
| ld_elem | input | 5 | Load target element |
| ld_data | input | 64 | Load value |
| issue | input | 1 | Instruction issue strobe |
| op | input | 1 | 0 add, 1 multiply |
| form | input | 1 | 0 vector-vector, 1 scalar-vector |
| dst | input | 5 | Destination register |
| srca | input | 5 | First operand register (vector-vector form) |
| srcb | input | 5 | Second operand register |
| scalar | input | 64 | Broadcast scalar (scalar-vector form) |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_reg | input | 5 | Inspection read register |
| rd_elem | input | 5 | Inspection read element |
| rd_data | output | 64 | Inspection read data |

## Verification
Two functions can land on the same clock edge: a length-register write and the acceptance of an instruction. The length write can also fall on a cycle while an instruction is running. The bench drives vl_we in the same cycle as issue, and again in the middle of a run. It then judges the element count in two ways: from how many destination elements changed, and from the number of cycles busy stays high. Both must match the length held before the issue edge. Issues and element loads driven while busy is high are also checked against a reference model that ignores them.

// File: rtl/vlalu_pkg.sv
package vlalu_pkg;
  localparam int DW = 64;

  typedef enum logic { OP_ADD = 1'b0, OP_MUL = 1'b1 } op_e;
  typedef enum logic { FORM_VV = 1'b0, FORM_SV = 1'b1 } form_e;
  typedef enum logic [1:0] { ST_IDLE, ST_RUN, ST_FIN } seq_state_e;

  // element arithmetic: sum or low half of product
  function automatic logic [DW-1:0] elem_op(op_e op, logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] r;
    if (op == OP_MUL) r = a * b;
    else              r = a + b;
    return r;
  endfunction

  // cap a requested length at the maximum
  function automatic int unsigned clamp_len(int unsigned req, int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction
endpackage

// File: rtl/vlalu_regfile.sv
module vlalu_regfile #(
  parameter int NREG = 32,
  parameter int MVL  = 32,
  parameter int DW   = 64,
  localparam int RW  = $clog2(NREG),
  localparam int EW  = $clog2(MVL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] w_reg,
  input  logic [EW-1:0] w_elem,
  input  logic [DW-1:0] w_data,
  input  logic [RW-1:0] ra_reg,
  input  logic [EW-1:0] ra_elem,
  output logic [DW-1:0] ra_data,
  input  logic [RW-1:0] rb_reg,
  input  logic [EW-1:0] rb_elem,
  output logic [DW-1:0] rb_data,
  input  logic [RW-1:0] rc_reg,
  input  logic [EW-1:0] rc_elem,
  output logic [DW-1:0] rc_data
);
  logic [DW-1:0] mem [NREG][MVL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int e = 0; e < MVL; e++)
          mem[r][e] <= '0;
    end else if (we) begin
      mem[w_reg][w_elem] <= w_data;
    end
  end

  // combinational reads: old value visible until the write edge
  assign ra_data = mem[ra_reg][ra_elem];
  assign rb_data = mem[rb_reg][rb_elem];
  assign rc_data = mem[rc_reg][rc_elem];
endmodule

// File: rtl/vlalu_vlreg.sv
module vlalu_vlreg #(
  parameter int MVL  = 32,
  parameter int IN_W = 8,
  localparam int VLW = $clog2(MVL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IN_W-1:0] wdata,
  output logic [VLW-1:0]  vl
);
  logic [VLW-1:0] capped;

  always_comb begin
    capped = VLW'(vlalu_pkg::clamp_len(int'(unsigned'(wdata)), MVL));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  vl <= VLW'(MVL);
    else if (we) vl <= capped;
  end
endmodule

// File: rtl/vlalu_seq.sv
module vlalu_seq #(
  parameter int MVL  = 32,
  localparam int EW  = $clog2(MVL),
  localparam int VLW = $clog2(MVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] start_cnt,
  output logic           run,
  output logic [EW-1:0]  idx,
  output logic [VLW-1:0] cnt,
  output logic           busy,
  output logic           done
);
  import vlalu_pkg::*;

  seq_state_e state;
  logic       last_elem;

  assign last_elem = ({1'b0, idx} == (cnt - VLW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          cnt   <= start_cnt;
          idx   <= '0;
          state <= (start_cnt == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          idx <= idx + EW'(1);
          if (last_elem) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign run  = (state == ST_RUN);
  assign done = (state == ST_FIN);
  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/vlen_vector_alu.sv
module vlen_vector_alu #(
  parameter int NREG   = 32,
  parameter int MVL    = 32,
  parameter int VLIN_W = 8,
  localparam int DW    = vlalu_pkg::DW,
  localparam int RW    = $clog2(NREG),
  localparam int EW    = $clog2(MVL),
  localparam int VLW   = $clog2(MVL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vl_we,
  input  logic [VLIN_W-1:0] vl_wdata,
  output logic [VLW-1:0]    vl_q,
  input  logic              ld_en,
  input  logic [RW-1:0]     ld_reg,
  input  logic [EW-1:0]     ld_elem,
  input  logic [DW-1:0]     ld_data,
  input  logic              issue,
  input  logic              op,
  input  logic              form,
  input  logic [RW-1:0]     dst,
  input  logic [RW-1:0]     srca,
  input  logic [RW-1:0]     srcb,
  input  logic [DW-1:0]     scalar,
  output logic              busy,
  output logic              done,
  input  logic [RW-1:0]     rd_reg,
  input  logic [EW-1:0]     rd_elem,
  output logic [DW-1:0]     rd_data
);
  import vlalu_pkg::*;

  // named internal events
  logic           accept;
  logic           ex_we;
  logic [EW-1:0]  ex_idx;
  logic [VLW-1:0] ex_cnt;
  logic           ld_take;

  op_e            op_q;
  form_e          form_q;
  logic [RW-1:0]  dst_q, srca_q, srcb_q;
  logic [DW-1:0]  scalar_q;

  logic [DW-1:0]  a_vec, b_vec, a_opnd, ex_res;
  logic           wr_en;
  logic [RW-1:0]  wr_reg;
  logic [EW-1:0]  wr_elem;
  logic [DW-1:0]  wr_data;

  assign accept  = issue & ~busy;
  assign ld_take = ld_en & ~busy;

  vlalu_vlreg #(.MVL(MVL), .IN_W(VLIN_W)) u_vlreg (
    .clk(clk), .rst_n(rst_n), .we(vl_we), .wdata(vl_wdata), .vl(vl_q)
  );

  vlalu_seq #(.MVL(MVL)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_cnt(vl_q),
    .run(ex_we), .idx(ex_idx), .cnt(ex_cnt), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= OP_ADD;
      form_q   <= FORM_VV;
      dst_q    <= '0;
      srca_q   <= '0;
      srcb_q   <= '0;
      scalar_q <= '0;
    end else if (accept) begin
      op_q     <= op_e'(op);
      form_q   <= form_e'(form);
      dst_q    <= dst;
      srca_q   <= srca;
      srcb_q   <= srcb;
      scalar_q <= scalar;
    end
  end

  assign a_opnd = (form_q == FORM_SV) ? scalar_q : a_vec;
  assign ex_res = elem_op(op_q, a_opnd, b_vec);

  // execution owns the write port while running
  always_comb begin
    if (ex_we) begin
      wr_en = 1'b1; wr_reg = dst_q;  wr_elem = ex_idx;  wr_data = ex_res;
    end else begin
      wr_en = ld_take; wr_reg = ld_reg; wr_elem = ld_elem; wr_data = ld_data;
    end
  end

  vlalu_regfile #(.NREG(NREG), .MVL(MVL), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .w_reg(wr_reg), .w_elem(wr_elem), .w_data(wr_data),
    .ra_reg(srca_q), .ra_elem(ex_idx), .ra_data(a_vec),
    .rb_reg(srcb_q), .rb_elem(ex_idx), .rb_data(b_vec),
    .rc_reg(rd_reg), .rc_elem(rd_elem), .rc_data(rd_data)
  );
endmodule

// File: rtl/vlen_vector_alu_chk.sv
module vlen_vector_alu_chk #(
  parameter int MVL  = 32,
  localparam int EW  = $clog2(MVL),
  localparam int VLW = $clog2(MVL + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           issue,
  input logic           busy,
  input logic           done,
  input logic           vl_we,
  input logic [VLW-1:0] vl_q,
  input logic           ex_we,
  input logic [EW-1:0]  ex_idx,
  input logic [VLW-1:0] ex_cnt
);
  AST_VL_CAPPED: assert property (@(posedge clk) disable iff (!rst_n) vl_q <= VLW'(MVL)); // R2
  AST_VL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !vl_we |=> $stable(vl_q)); // R2
  AST_ISSUE_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (issue && !busy) |=> busy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R8
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R8
  AST_ELEM_BOUND: assert property (@(posedge clk) disable iff (!rst_n) ex_we |-> ({1'b0, ex_idx} < ex_cnt)); // R6
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R9
endmodule

bind vlen_vector_alu vlen_vector_alu_chk #(.MVL(MVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .busy(busy), .done(done),
  .vl_we(vl_we), .vl_q(vl_q), .ex_we(ex_we), .ex_idx(ex_idx), .ex_cnt(ex_cnt)
);

// File: tb/vlen_vector_alu_tb.sv
module vlen_vector_alu_tb;
  localparam int CLK_P = 10;
  localparam int NREG  = 32;
  localparam int MVL   = 32;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        vl_we = 0;
  logic [7:0]  vl_wdata = 0;
  logic [5:0]  vl_q;
  logic        ld_en = 0;
  logic [4:0]  ld_reg = 0, ld_elem = 0;
  logic [63:0] ld_data = 0;
  logic        issue = 0, op = 0, form = 0;
  logic [4:0]  dst = 0, srca = 0, srcb = 0;
  logic [63:0] scalar = 0;
  logic        busy, done;
  logic [4:0]  rd_reg = 0, rd_elem = 0;
  logic [63:0] rd_data;

  int n_chk = 0, n_fail = 0, cyc = 0;

  vlen_vector_alu u_dut (
    .clk(clk), .rst_n(rst_n), .vl_we(vl_we), .vl_wdata(vl_wdata), .vl_q(vl_q),
    .ld_en(ld_en), .ld_reg(ld_reg), .ld_elem(ld_elem), .ld_data(ld_data),
    .issue(issue), .op(op), .form(form), .dst(dst), .srca(srca), .srcb(srcb),
    .scalar(scalar), .busy(busy), .done(done),
    .rd_reg(rd_reg), .rd_elem(rd_elem), .rd_data(rd_data)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  logic [63:0] m_mem [NREG][MVL];
  int          m_vl, m_n, m_i;
  bit          m_run, m_done, m_op, m_form;
  int          m_d, m_a, m_b;
  logic [63:0] m_sc, av, bv;
  bit          was_busy;
  int          old_vl;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) for (int e = 0; e < MVL; e++) m_mem[r][e] = 0;
      m_vl = MVL; m_run = 0; m_done = 0; m_i = 0; m_n = 0;
    end else begin
      was_busy = m_run || m_done;
      old_vl = m_vl;
      if (m_run) begin
        av = m_form ? m_sc : m_mem[m_a][m_i];
        bv = m_mem[m_b][m_i];
        m_mem[m_d][m_i] = m_op ? av * bv : av + bv;
        m_i++;
        if (m_i == m_n) begin m_run = 0; m_done = 1; end
      end else if (m_done) begin
        m_done = 0;
      end else if (issue) begin
        m_op = op; m_form = form; m_d = dst; m_a = srca; m_b = srcb; m_sc = scalar;
        m_n = old_vl; m_i = 0;
        if (m_n == 0) m_done = 1; else m_run = 1;
      end
      if (ld_en && !was_busy) m_mem[ld_reg][ld_elem] = ld_data;
      if (vl_we) m_vl = (vl_wdata > MVL) ? MVL : vl_wdata;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the control outputs
  always @(negedge clk) begin
    if (rst_n) begin
      check("R8 busy", busy, m_run || m_done);
      check("R8 done", done, m_done);
      check("R2 vl", vl_q, m_vl);
    end
  end

  task automatic chk_reg(int r, string tag);
    for (int e = 0; e < MVL; e++) begin
      rd_reg = r; rd_elem = e; #1;
      check(tag, rd_data, m_mem[r][e]);
    end
  endtask

  task automatic load(int r, int e, logic [63:0] v);
    @(negedge clk); ld_en = 1; ld_reg = r; ld_elem = e; ld_data = v;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic set_vl(int v);
    @(negedge clk); vl_we = 1; vl_wdata = v;
    @(negedge clk); vl_we = 0;
  endtask

  task automatic run_op(bit o, bit f, int d, int a, int b, logic [63:0] s, int exp_vl);
    int cnt;
    @(negedge clk); issue = 1; op = o; form = f; dst = d; srca = a; srcb = b; scalar = s;
    @(negedge clk); issue = 0; scalar = 64'hDEAD_BEEF_0BAD_F00D;
    cnt = 1;
    while (!done) begin @(negedge clk); cnt++; end
    check("R8 latency", cnt, exp_vl + 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 vl reset", vl_q, MVL);
    check("R1 busy reset", busy, 0);
    rd_reg = 7; rd_elem = 3; #1; check("R1 elem reset", rd_data, 0);

    // fill sources and a destination with patterns (R12)
    for (int e = 0; e < MVL; e++) begin
      load(1, e, 64'h1000 + e * 3);
      load(2, e, 64'hFFFF_FFFF_FFFF_FFF0 + e);
      load(4, e, 64'hA5A5_0000 + e);
    end
    chk_reg(1, "R12 load");

    run_op(0, 0, 3, 1, 2, 0, MVL);
    chk_reg(3, "R3 vv add wrap");

    set_vl(100);
    check("R2 clamp", vl_q, MVL);
    set_vl(10);
    check("R2 write", vl_q, 10);
    run_op(1, 1, 4, 0, 1, 64'h0000_0001_0000_0003, 10);
    chk_reg(4, "R4 R6 sv mul tail kept");

    run_op(1, 0, 5, 2, 2, 0, 10);
    chk_reg(5, "R5 mul low half");

    set_vl(7);
    run_op(0, 0, 1, 1, 1, 0, 7);
    chk_reg(1, "R10 alias");

    set_vl(0);
    run_op(0, 0, 2, 1, 1, 0, 0);
    chk_reg(2, "R7 zero length");

    // issue and load while busy must be ignored
    set_vl(6);
    @(negedge clk); issue = 1; op = 0; form = 1; dst = 8; srcb = 1; scalar = 5;
    @(negedge clk); issue = 1; op = 1; dst = 9; srcb = 2;
    ld_en = 1; ld_reg = 10; ld_elem = 2; ld_data = 64'h1234;
    @(negedge clk); issue = 0; ld_en = 0;
    while (busy) @(negedge clk);
    chk_reg(8, "R9 first op");
    chk_reg(9, "R9 ignored issue");
    rd_reg = 10; rd_elem = 2; #1; check("R12 load while busy", rd_data, 0);

    // length write coinciding with issue and during run
    set_vl(5);
    @(negedge clk); issue = 1; op = 0; form = 0; dst = 11; srca = 1; srcb = 3;
    vl_we = 1; vl_wdata = 20;
    @(negedge clk); issue = 0; vl_we = 0;
    @(negedge clk); vl_we = 1; vl_wdata = 2;
    @(negedge clk); vl_we = 0;
    while (busy) @(negedge clk);
    chk_reg(11, "R11 old length used");
    check("R11 later length", vl_q, 2);
    run_op(0, 1, 12, 0, 3, 64'd1, 2);
    chk_reg(12, "R11 new length");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule